// File: doc/BRIEF.md
# Frame-Synchronous Sample Source and Capture Sequencer

This block sits on the tester side of a mixed-signal device under test. It runs the digital half of a coherent converter test. It holds a stimulus record in a local source memory and plays that record out on an 8-bit parallel bus, one word per sampling frame. In the same frame it takes one word from the device's 8-bit converter output bus and stores it in a local capture memory. Software-free operation is assumed: the source memory is filled through a simple write port, the run is started and stopped with two pulses, and captured words are read back through a registered read port.

Each frame is `FRAME_VECS` vectors long (16 by default). Each vector lasts `MCLK_DIV` clocks (2 by default). A master-clock enable marks the first clock of every vector, and a frame sync marks the first vector of every frame. Only three vector kinds exist. The quiet vector carries code 00 and data 0. The transfer vector carries code 10; during it the next source word is driven and the converter output is stored. The marker vector carries code 01, and during it the data bus is forced to all ones. Within a frame the order is fixed: a quiet vector first (with the sync), then the transfer vector, then the marker, then quiet vectors to the end of the frame. The source address wraps after a programmable record length, so the stimulus repeats every N frames. The capture stops after a programmable count and raises a done flag.

Top module: `sample_frame_seq`

## Requirements
- R1: While `rst` is high and on the first clock after it, `mclk_en`, `fsync`, `vec_ctrl`, `dac_data`, `busy` and `done` are all zero.
- R2: After `start` is sampled, outputs follow a frame of `FRAME_VECS` vectors of `MCLK_DIV` clocks each, starting on the next clock. `mclk_en` is high on the first clock of every vector. `fsync` is a one-clock pulse on the first clock of vector 0, so consecutive syncs are exactly `FRAME_VECS` master clocks (32 clocks by default) apart.
- R3: `vec_ctrl` is 2'b10 during vector 1 and 2'b01 during vector 2. For vector 0 and vectors 3 and up, `vec_ctrl` is 2'b00 and `dac_data` is 0. The code 2'b11 never appears.
- R4: During vector 1, `dac_data` carries the current source word. During vector 2, `dac_data` is all ones.
- R5: Source words are played from address 0 upward, one per frame. After word `rec_len`-1 the address returns to 0. A `rec_len` of 0 or 1 replays word 0 in every frame.
- R6: The value on `adc_data` during vector 1 of each frame is written to capture addresses 0, 1, 2, … in turn. `cap_rd_data` returns the word at `cap_rd_addr` one clock after the address is applied.
- R7: Once `cap_count` words have been stored, `done` rises on the clock of the last store. Later transfer vectors leave every capture location unchanged. With `cap_count` = 0, `done` is high from the clock after `start`, and nothing is written.
- R8: `start` begins a fresh run even in the middle of a frame. It resets the source address, the capture address and the frame position, clears `done`, latches `rec_len` and `cap_count`, and raises `busy`.
- R9: The clock that samples `stop` drops `busy`. From the clock after that, `mclk_en`, `fsync`, `vec_ctrl` and `dac_data` stay zero. `done` and the capture memory keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run (pulse) |
| stop | input | 1 | End the run (pulse) |
| rec_len | input | AW+1 | Source record length N, latched at start |
| cap_count | input | AW+1 | Number of words to capture M, latched at start |
| src_wr_en | input | 1 | Source memory write enable |
| src_wr_addr | input | AW | Source memory write address |
| src_wr_data | input | DW | Source memory write data |
| adc_data | input | DW | Converter output bus from the device |
| cap_rd_addr | input | AW | Capture memory read address |
| cap_rd_data | output | DW | Capture memory read data, one clock latency |
| mclk_en | output | 1 | Master-clock enable, first clock of each vector |
| fsync | output | 1 | Frame sync pulse |
| vec_ctrl | output | 2 | Vector control code |
| dac_data | output | DW | Stimulus bus to the device |
| busy | output | 1 | Run in progress |
| done | output | 1 | Capture count reached |

## Verification
A slip in the vector or divider counters moves `fsync`, `mclk_en` or the transfer code away from their computed clocks, so the error shows on the ports within one frame of the fault. A wrong source address shows as a wrong word on `dac_data` in the next transfer vector. A wrap fault shows up at the latest after `rec_len` frames. A wrong capture address or a missed stop on `done` cannot be seen on the live bus. It appears only when capture memory is read back after the run, where a word sits at the wrong address or a location beyond the count has been overwritten. `done` itself can be compared on every clock against the store count derived from the frame timing.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    VEC_QUIET  = 2'b00,
    VEC_MARKER = 2'b01,
    VEC_XFER   = 2'b10
  } vec_code_e;

  // Positions inside the frame; the order is part of the behaviour.
  localparam int XFER_POS   = 1;
  localparam int MARKER_POS = 2;
endpackage

// File: rtl/sfs_frame_timer.sv
module sfs_frame_timer #(
  parameter int MCLK_DIV   = 2,
  parameter int FRAME_VECS = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          restart,
  input  logic                          run,
  output logic [$clog2(FRAME_VECS)-1:0] slot,
  output logic                          vec_first,
  output logic                          vec_last
);
  localparam int DCW = (MCLK_DIV > 1) ? $clog2(MCLK_DIV) : 1;
  localparam int SW  = $clog2(FRAME_VECS);
  localparam logic [DCW-1:0] DMAX = DCW'(MCLK_DIV - 1);
  localparam logic [SW-1:0]  SMAX = SW'(FRAME_VECS - 1);

  logic [DCW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      dcnt <= '0;
      slot <= '0;
    end else if (run) begin
      if (dcnt == DMAX) begin
        dcnt <= '0;
        slot <= (slot == SMAX) ? '0 : slot + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign vec_first = (dcnt == '0);
  assign vec_last  = (dcnt == DMAX);
endmodule

// File: rtl/sfs_src_store.sv
module sfs_src_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  input  logic [AW:0]   len_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr;
  logic [AW:0]   len_q;
  logic [AW:0]   addr_inc;

  assign addr_inc = {1'b0, addr} + (AW+1)'(1);

  // Block-RAM style: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      len_q <= '0;
    end else if (restart) begin
      addr  <= '0;
      len_q <= len_in;
    end else if (advance) begin
      addr <= (addr_inc >= len_q) ? '0 : addr_inc[AW-1:0];
    end
  end
endmodule

// File: rtl/sfs_cap_store.sv
module sfs_cap_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [AW:0]   limit_in,
  input  logic          store,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          full
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   addr;
  logic [AW:0]   limit_q;
  logic          wr_en;

  assign wr_en = store && !full;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr[AW-1:0]] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      limit_q <= '0;
      full    <= 1'b0;
    end else if (restart) begin
      addr    <= '0;
      limit_q <= limit_in;
      full    <= (limit_in == '0);
    end else if (wr_en) begin
      addr <= addr + 1'b1;
      full <= (addr + 1'b1 == limit_q);
    end
  end
endmodule

// File: rtl/sample_frame_seq.sv
module sample_frame_seq
  import sfs_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 6,
  parameter int MCLK_DIV   = 2,
  parameter int FRAME_VECS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [AW:0]   rec_len,
  input  logic [AW:0]   cap_count,
  input  logic          src_wr_en,
  input  logic [AW-1:0] src_wr_addr,
  input  logic [DW-1:0] src_wr_data,
  input  logic [DW-1:0] adc_data,
  input  logic [AW-1:0] cap_rd_addr,
  output logic [DW-1:0] cap_rd_data,
  output logic          mclk_en,
  output logic          fsync,
  output logic [1:0]    vec_ctrl,
  output logic [DW-1:0] dac_data,
  output logic          busy,
  output logic          done
);
  localparam int SW = $clog2(FRAME_VECS);
  localparam logic [SW-1:0] XFER_S   = SW'(XFER_POS);
  localparam logic [SW-1:0] MARKER_S = SW'(MARKER_POS);

  logic          run_q;
  logic [SW-1:0] slot;
  logic          vec_first;
  logic          vec_last;
  logic          xfer_end;
  logic [DW-1:0] src_word;
  vec_code_e     code_q;

  always_ff @(posedge clk) begin
    if (rst)        run_q <= 1'b0;
    else if (start) run_q <= 1'b1;
    else if (stop)  run_q <= 1'b0;
  end

  sfs_frame_timer #(.MCLK_DIV(MCLK_DIV), .FRAME_VECS(FRAME_VECS)) u_timer (
    .clk(clk), .rst(rst), .restart(start), .run(run_q),
    .slot(slot), .vec_first(vec_first), .vec_last(vec_last)
  );

  assign xfer_end = run_q && !start && (slot == XFER_S) && vec_last;

  sfs_src_store #(.DW(DW), .AW(AW)) u_src (
    .clk(clk), .rst(rst), .restart(start), .advance(xfer_end),
    .len_in(rec_len), .wr_en(src_wr_en), .wr_addr(src_wr_addr),
    .wr_data(src_wr_data), .rd_data(src_word)
  );

  sfs_cap_store #(.DW(DW), .AW(AW)) u_cap (
    .clk(clk), .rst(rst), .restart(start), .limit_in(cap_count),
    .store(xfer_end), .wr_data(adc_data), .rd_addr(cap_rd_addr),
    .rd_data(cap_rd_data), .full(done)
  );

  // Registered vector outputs.
  always_ff @(posedge clk) begin
    if (rst || !run_q) begin
      mclk_en  <= 1'b0;
      fsync    <= 1'b0;
      code_q   <= VEC_QUIET;
      dac_data <= '0;
    end else begin
      mclk_en <= vec_first;
      fsync   <= vec_first && (slot == '0);
      if (slot == XFER_S) begin
        code_q   <= VEC_XFER;
        dac_data <= src_word;
      end else if (slot == MARKER_S) begin
        code_q   <= VEC_MARKER;
        dac_data <= '1;
      end else begin
        code_q   <= VEC_QUIET;
        dac_data <= '0;
      end
    end
  end

  assign vec_ctrl = code_q;
  assign busy     = run_q;
endmodule

// File: rtl/sfs_seq_checker.sv
module sfs_seq_checker #(
  parameter int DW         = 8,
  parameter int MCLK_DIV   = 2,
  parameter int FRAME_VECS = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mclk_en,
  input logic          fsync,
  input logic [1:0]    vec_ctrl,
  input logic [DW-1:0] dac_data,
  input logic          busy,
  input logic          done
);
  localparam int FRAME_CLKS = MCLK_DIV * FRAME_VECS;

  logic start_q;
  logic seen;
  int   gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      seen    <= 1'b0;
      gap     <= 0;
    end else begin
      start_q <= start;
      if (start || start_q) begin
        seen <= 1'b0;
        gap  <= 0;
      end else if (fsync) begin
        seen <= 1'b1;
        gap  <= 0;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  // R2
  fsync_on_mclk_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |-> mclk_en);

  // R2
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync && seen && !start_q) |-> (gap == FRAME_CLKS - 1));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    vec_ctrl != 2'b11);

  // R3
  quiet_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ctrl == 2'b00) |-> (dac_data == '0));

  // R4
  marker_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ctrl == 2'b01) |-> (dac_data == '1));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (vec_ctrl == 2'b00 && !fsync && !mclk_en));
endmodule

bind sample_frame_seq sfs_seq_checker #(
  .DW(DW), .MCLK_DIV(MCLK_DIV), .FRAME_VECS(FRAME_VECS)
) i_sfs_chk (
  .clk(clk), .rst(rst), .start(start), .mclk_en(mclk_en), .fsync(fsync),
  .vec_ctrl(vec_ctrl), .dac_data(dac_data), .busy(busy), .done(done)
);

// File: tb/test_sample_frame_seq.sv
module test_sample_frame_seq;
  localparam int DW  = 8;
  localparam int AW  = 6;
  localparam int DIV = 2;
  localparam int FV  = 16;
  localparam int FR  = DIV * FV;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic [AW:0]   rec_len = '0;
  logic [AW:0]   cap_count = '0;
  logic          src_wr_en = 1'b0;
  logic [AW-1:0] src_wr_addr = '0;
  logic [DW-1:0] src_wr_data = '0;
  logic [DW-1:0] adc_data = '0;
  logic [AW-1:0] cap_rd_addr = '0;
  logic [DW-1:0] cap_rd_data;
  logic          mclk_en, fsync, busy, done;
  logic [1:0]    vec_ctrl;
  logic [DW-1:0] dac_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sample_frame_seq #(.DW(DW), .AW(AW), .MCLK_DIV(DIV), .FRAME_VECS(FV)) i_sample_frame_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .rec_len(rec_len),
    .cap_count(cap_count), .src_wr_en(src_wr_en), .src_wr_addr(src_wr_addr),
    .src_wr_data(src_wr_data), .adc_data(adc_data), .cap_rd_addr(cap_rd_addr),
    .cap_rd_data(cap_rd_data), .mclk_en(mclk_en), .fsync(fsync),
    .vec_ctrl(vec_ctrl), .dac_data(dac_data), .busy(busy), .done(done)
  );

  function automatic logic [DW-1:0] src_word(int i);
    return DW'(i * 7 + 3);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Pulse start, then check every clock of nf frames against the frame model.
  task automatic run_frames(int nf, int n_len, int m_cnt, int base);
    rec_len   = (AW+1)'(n_len);
    cap_count = (AW+1)'(m_cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    adc_data = DW'(base);
    for (int c = 1; c <= nf * FR; c++) begin
      int t, slot, frame, idx, exp_ctrl, exp_dac;
      bit exp_mclk, exp_fs, exp_done;
      @(negedge clk);
      adc_data = DW'(base + c / FR);
      t = c - 1;
      slot = (t / DIV) % FV;
      frame = t / FR;
      exp_mclk = (t % DIV) == 0;
      exp_fs = exp_mclk && slot == 0;
      idx = (n_len <= 1) ? 0 : frame % n_len;
      exp_ctrl = (slot == 1) ? 2 : (slot == 2) ? 1 : 0;
      exp_dac = (slot == 1) ? int'(src_word(idx)) : (slot == 2) ? 255 : 0;
      exp_done = (m_cnt == 0) ? 1'b1 : (c >= (m_cnt - 1) * FR + 2 * DIV);
      chk(mclk_en == exp_mclk, "R2 mclk_en", mclk_en, exp_mclk);
      chk(fsync == exp_fs, "R2 fsync", fsync, exp_fs);
      chk(vec_ctrl == 2'(exp_ctrl), "R3 vec_ctrl", vec_ctrl, exp_ctrl);
      chk(dac_data == DW'(exp_dac), "R4 R5 dac_data", dac_data, exp_dac);
      chk(done == exp_done, "R7 done", done, exp_done);
      chk(busy == 1'b1, "R8 busy", busy, 1);
    end
  endtask

  task automatic cap_expect(int addr, int exp, string tag);
    cap_rd_addr = AW'(addr);
    @(negedge clk);
    chk(cap_rd_data == DW'(exp), tag, cap_rd_data, exp);
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0, "R9 busy low", busy, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(mclk_en == 0 && fsync == 0 && vec_ctrl == 0 && dac_data == 0,
        "R1 outputs idle in reset", {mclk_en, fsync, vec_ctrl}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(vec_ctrl == 0 && dac_data == 0, "R1 bus", dac_data, 0);
    for (int i = 0; i < (1 << AW); i++) begin
      src_wr_en = 1'b1; src_wr_addr = AW'(i); src_wr_data = src_word(i);
      @(negedge clk);
    end
    src_wr_en = 1'b0;
  endtask

  // R5 wrap at 5, R6 capture of 8 words
  task automatic t_basic();
    run_frames(12, 5, 8, 8'h40);
    do_stop();
    for (int k = 0; k < 8; k++) cap_expect(k, 8'h40 + k, "R6 capture word");
  endtask

  // R7 stores after the count leave later locations alone
  task automatic t_ignore();
    run_frames(6, 64, 3, 8'h80);
    do_stop();
    for (int k = 0; k < 3; k++) cap_expect(k, 8'h80 + k, "R6 capture word");
    for (int k = 3; k < 8; k++) cap_expect(k, 8'h40 + k, "R7 beyond count kept");
  endtask

  // R7 zero count, R5 record length 1 replays word 0
  task automatic t_zero();
    run_frames(3, 1, 0, 8'hC0);
    do_stop();
    for (int k = 0; k < 3; k++) cap_expect(k, 8'h80 + k, "R7 zero count no write");
    run_frames(2, 0, 1, 8'hD0);
    do_stop();
    cap_expect(0, 8'hD0, "R5 R6 zero length run");
  endtask

  // R8 restart in the middle of a frame
  task automatic t_restart();
    run_frames(2, 7, 4, 8'h10);
    repeat (7) @(negedge clk);
    run_frames(5, 7, 4, 8'h20);
    do_stop();
    for (int k = 0; k < 4; k++) cap_expect(k, 8'h20 + k, "R8 restart capture");
  endtask

  // R9 idle after stop, done kept
  task automatic t_stop();
    run_frames(3, 4, 2, 8'h55);
    do_stop();
    for (int i = 0; i < FR + 3; i++) begin
      chk(mclk_en == 0 && fsync == 0 && vec_ctrl == 0 && dac_data == 0,
          "R9 idle after stop", {mclk_en, fsync, vec_ctrl, dac_data}, 0);
      @(negedge clk);
    end
    chk(done == 1, "R9 done kept", done, 1);
    cap_expect(1, 8'h56, "R9 capture kept");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignore();
    t_zero();
    t_restart();
    t_stop();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule